// File: doc/BRIEF.md
# Ternary Content Addressable Memory

This block is a synchronous ternary lookup table. It holds 128 entries of 48 bits, and each stored bit is either an exact 0, an exact 1, or a wildcard that accepts any key bit. The block runs one of three operations in each enabled clock cycle:

- **Update:** stores the data bus into one addressed entry, the same way a RAM write works.
- **Search:** compares the data bus, used as a key, against every valid entry in parallel.
- **Mask load:** copies the data bus into a shared mask register.

A search returns three results:

- a hit flag;
- a flag that shows two or more entries hit;
- the lowest-numbered hitting entry.

The shared mask does two jobs, and each is opt-in for the operation in hand. During an update it protects the chosen bit positions from change. During a search it removes those bit positions from the comparison. A wildcard strobe on an update turns the written bits into wildcards, and it follows the same protection rule. A parameter `REG_OUT` selects the result timing. When it is 1, the results are registered. When it is 0, they come straight from the compare logic.

Top module: `tcam_core`

## Requirements
- R1: A cycle with `ce`, `wr_en` and `wr_cs` all high stores `din` into entry `wr_addr`, marks that entry valid, and replaces any earlier content there.
- R2: When `wr_cs` is low, the cycle does not write, even if `wr_en` is high. An entry that was never written never hits.
- R3: A search cycle is a cycle with `ce` high that is neither a write nor a mask load. In a search cycle, `hit` is 1 if at least one valid entry accepts the key. While `hit` is 0, `hit_addr` is 0.
- R4: `multi_hit` is 1 only when two or more valid entries accept the key.
- R5: When several entries hit, `hit_addr` gives the lowest entry number among them.
- R6: During a write with `mask_en` high, each bit position whose mask bit is 1 keeps its old stored value and wildcard state.
- R7: During a search with `mask_en` high, each bit position whose mask bit is 1 is left out of the comparison for every entry.
- R8: A write with `wr_dc` high turns the written bit positions into wildcards, and these accept both key values. Positions protected as in R6 keep their old value.
- R9: A cycle with `ce` and `mask_ld` high, and no write, loads the mask register from `din`. Bit i of the mask governs data bit i.
- R10: While `ce` is low, no input is sampled and `hit`, `multi_hit` and `hit_addr` hold their values.
- R11: Reset does the following:
  - invalidates every entry;
  - clears the mask register;
  - clears the stored key;
  - clears all three outputs.
- R12: With `REG_OUT`=1, the results for a key sampled at a rising edge appear one enabled rising edge later. With `REG_OUT`=0, they appear right after the sampling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Clock enable for all inputs and outputs |
| wr_en | input | 1 | Write request |
| wr_cs | input | 1 | Write select; a write needs both `wr_en` and `wr_cs` |
| wr_dc | input | 1 | Write the selected bits as wildcards |
| mask_en | input | 1 | Apply the mask register to this write or search |
| mask_ld | input | 1 | Load the mask register from `din` |
| din | input | 48 | Write data, search key or mask value |
| wr_addr | input | 7 | Entry written by an update |
| hit | output | 1 | At least one entry hit |
| multi_hit | output | 1 | Two or more entries hit |
| hit_addr | output | 7 | Lowest hitting entry, or 0 when nothing hits |

## Verification
The bench uses the default registered mode. Timing works as follows:

- A key is sampled on one rising edge, and its results settle on the next enabled rising edge.
- A write or a mask load takes effect on the edge that samples it.

Each search holds its key through two rising edges and reads the outputs at the falling edge that follows. A directed check reads one falling edge earlier, to confirm that the previous result is still showing. The clock-enable check reads the outputs across stalled cycles, before any new enabled edge.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

    localparam int unsigned TC_ENTRIES = 128;
    localparam int unsigned TC_WIDTH   = 48;

    typedef enum logic [1:0] {
        OP_SEARCH = 2'd0,
        OP_WRITE  = 2'd1,
        OP_MASK   = 2'd2
    } tc_op_e;

    // a write wins over a mask load; anything else is a search
    function automatic tc_op_e tc_decode(input logic wr_en, input logic wr_cs,
                                         input logic mask_ld);
        if (wr_en && wr_cs) return OP_WRITE;
        if (mask_ld)        return OP_MASK;
        return OP_SEARCH;
    endfunction

endpackage

// File: rtl/tcam_keyreg.sv
module tcam_keyreg
    import tcam_pkg::*;
#(
    parameter int unsigned WIDTH = TC_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  tc_op_e           op,
    input  logic [WIDTH-1:0] din,
    input  logic             mask_en,
    output logic [WIDTH-1:0] key_q,
    output logic             srch_men_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            key_q      <= '0;
            srch_men_q <= 1'b0;
        end else if (ce && op == OP_SEARCH) begin
            key_q      <= din;
            srch_men_q <= mask_en;
        end
    end

endmodule

// File: rtl/tcam_row.sv
module tcam_row #(
    parameter int unsigned WIDTH = 48,
    parameter int unsigned AW    = 7,
    parameter int unsigned IDX   = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] din,
    input  logic             wr_dc,
    input  logic [WIDTH-1:0] keep,
    input  logic [WIDTH-1:0] key,
    input  logic [WIDTH-1:0] ignore,
    output logic             hit
);

    logic             valid_q;
    logic [WIDTH-1:0] care_q;
    logic [WIDTH-1:0] data_q;
    logic             sel;

    assign sel = we && (wr_addr == AW'(IDX));

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            care_q  <= '1;
            data_q  <= '0;
        end else if (sel) begin
            valid_q <= 1'b1;
            care_q  <= (care_q & keep) | (~keep & {WIDTH{~wr_dc}});
            data_q  <= (data_q & keep) | (din & ~keep);
        end
    end

    assign hit = valid_q && (((data_q ^ key) & care_q & ~ignore) == '0);

endmodule

// File: rtl/tcam_resolve.sv
module tcam_resolve #(
    parameter int unsigned N  = 128,
    parameter int unsigned AW = 7
) (
    input  logic [N-1:0]  hits,
    output logic          any,
    output logic          multi,
    output logic [AW-1:0] addr
);

    logic [N-1:0] rest;

    // clearing the lowest set bit leaves something only if two or more were set
    assign rest  = hits & (hits - N'(1));
    assign any   = |hits;
    assign multi = |rest;

    always_comb begin
        addr = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) addr = AW'(i);
        end
    end

endmodule

// File: rtl/tcam_outstage.sv
module tcam_outstage #(
    parameter int unsigned AW      = 7,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce,
    input  logic          any_d,
    input  logic          multi_d,
    input  logic [AW-1:0] addr_d,
    output logic          any_o,
    output logic          multi_o,
    output logic [AW-1:0] addr_o
);

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    any_o   <= 1'b0;
                    multi_o <= 1'b0;
                    addr_o  <= '0;
                end else if (ce) begin
                    any_o   <= any_d;
                    multi_o <= multi_d;
                    addr_o  <= addr_d;
                end
            end
        end else begin : g_comb
            assign any_o   = any_d;
            assign multi_o = multi_d;
            assign addr_o  = addr_d;
        end
    endgenerate

endmodule

// File: rtl/tcam_core.sv
module tcam_core
    import tcam_pkg::*;
#(
    parameter int unsigned ENTRIES = TC_ENTRIES,
    parameter int unsigned WIDTH   = TC_WIDTH,
    parameter bit          REG_OUT = 1'b1,
    localparam int unsigned AW     = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic             wr_en,
    input  logic             wr_cs,
    input  logic             wr_dc,
    input  logic             mask_en,
    input  logic             mask_ld,
    input  logic [WIDTH-1:0] din,
    input  logic [AW-1:0]    wr_addr,
    output logic             hit,
    output logic             multi_hit,
    output logic [AW-1:0]    hit_addr
);

    tc_op_e             op;
    logic [WIDTH-1:0]   mask_q;
    logic [WIDTH-1:0]   key_q;
    logic               srch_men_q;
    logic [WIDTH-1:0]   keep;
    logic [WIDTH-1:0]   ignore;
    logic               we;
    logic [ENTRIES-1:0] hits;
    logic               any_d;
    logic               multi_d;
    logic [AW-1:0]      addr_d;

    assign op     = tc_decode(wr_en, wr_cs, mask_ld);
    assign we     = ce && (op == OP_WRITE);
    assign keep   = mask_en    ? mask_q : '0;
    assign ignore = srch_men_q ? mask_q : '0;

    always_ff @(posedge clk) begin
        if (rst)                       mask_q <= '0;
        else if (ce && op == OP_MASK)  mask_q <= din;
    end

    tcam_keyreg #(.WIDTH(WIDTH)) u_key (
        .clk        (clk),
        .rst        (rst),
        .ce         (ce),
        .op         (op),
        .din        (din),
        .mask_en    (mask_en),
        .key_q      (key_q),
        .srch_men_q (srch_men_q)
    );

    generate
        for (genvar e = 0; e < int'(ENTRIES); e++) begin : g_row
            tcam_row #(.WIDTH(WIDTH), .AW(AW), .IDX(e)) u_row (
                .clk     (clk),
                .rst     (rst),
                .we      (we),
                .wr_addr (wr_addr),
                .din     (din),
                .wr_dc   (wr_dc),
                .keep    (keep),
                .key     (key_q),
                .ignore  (ignore),
                .hit     (hits[e])
            );
        end
    endgenerate

    tcam_resolve #(.N(ENTRIES), .AW(AW)) u_res (
        .hits  (hits),
        .any   (any_d),
        .multi (multi_d),
        .addr  (addr_d)
    );

    tcam_outstage #(.AW(AW), .REG_OUT(REG_OUT)) u_out (
        .clk     (clk),
        .rst     (rst),
        .ce      (ce),
        .any_d   (any_d),
        .multi_d (multi_d),
        .addr_d  (addr_d),
        .any_o   (hit),
        .multi_o (multi_hit),
        .addr_o  (hit_addr)
    );

endmodule

// File: rtl/tcam_core_chk.sv
module tcam_core_chk #(
    parameter int unsigned WIDTH = 48,
    parameter int unsigned AW    = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             ce,
    input logic             wr_en,
    input logic             wr_cs,
    input logic             mask_ld,
    input logic [WIDTH-1:0] din,
    input logic [WIDTH-1:0] mask_q,
    input logic             hit,
    input logic             multi_hit,
    input logic [AW-1:0]    hit_addr
);

    // R11
    rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!hit && !multi_hit && hit_addr == '0));

    // R3
    miss_addr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !hit |-> hit_addr == '0);

    // R4
    multi_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
        multi_hit |-> hit);

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ce |=> ($stable(hit) && $stable(multi_hit) && $stable(hit_addr)));

    // R9
    mask_load_chk: assert property (@(posedge clk) disable iff (rst)
        (ce && mask_ld && !(wr_en && wr_cs)) |=> mask_q == $past(din));

endmodule

bind tcam_core tcam_core_chk #(.WIDTH(WIDTH), .AW(AW)) u_chk (.*);

// File: tb/tb_tcam_core.sv
`timescale 1ns/1ps
module tb_tcam_core;

    localparam int W  = 48;
    localparam int AW = 7;

    logic          clk = 1'b0;
    logic          rst, ce, wr_en, wr_cs, wr_dc, mask_en, mask_ld;
    logic [W-1:0]  din;
    logic [AW-1:0] wr_addr;
    logic          hit, multi_hit;
    logic [AW-1:0] hit_addr;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    tcam_core dut (
        .clk(clk), .rst(rst), .ce(ce), .wr_en(wr_en), .wr_cs(wr_cs),
        .wr_dc(wr_dc), .mask_en(mask_en), .mask_ld(mask_ld), .din(din),
        .wr_addr(wr_addr), .hit(hit), .multi_hit(multi_hit), .hit_addr(hit_addr)
    );

    // op: 0 write, 1 search, 2 mask load
    typedef struct packed {
        logic [1:0]    op;
        logic          dc;
        logic          men;
        logic          cs;
        logic [AW-1:0] addr;
        logic [W-1:0]  data;
        logic          ehit;
        logic          emul;
        logic [AW-1:0] eaddr;
        logic [3:0]    req;
    } vec_t;

    localparam logic [W-1:0] KA = 48'h1234_5678_9ABC;
    localparam logic [W-1:0] KC = 48'hCAFE_0000_BEEF;
    localparam int NV = 18;

    localparam vec_t TBL [NV] = '{
        '{2'd0, 1'b0, 1'b0, 1'b1, 7'd5,  KA,               1'b0, 1'b0, 7'd0,  4'd1},  // R1
        '{2'd1, 1'b0, 1'b0, 1'b0, 7'd0,  KA,               1'b1, 1'b0, 7'd5,  4'd3},  // R3
        '{2'd0, 1'b0, 1'b0, 1'b1, 7'd9,  KA,               1'b0, 1'b0, 7'd0,  4'd1},
        '{2'd1, 1'b0, 1'b0, 1'b0, 7'd0,  KA,               1'b1, 1'b1, 7'd5,  4'd4},  // R4 R5
        '{2'd1, 1'b0, 1'b0, 1'b0, 7'd0,  48'h0,            1'b0, 1'b0, 7'd0,  4'd3},
        '{2'd2, 1'b0, 1'b0, 1'b0, 7'd0,  48'hFF,           1'b0, 1'b0, 7'd0,  4'd9},  // R9
        '{2'd1, 1'b0, 1'b1, 1'b0, 7'd0,  KA ^ 48'h55,      1'b1, 1'b1, 7'd5,  4'd7},  // R7
        '{2'd1, 1'b0, 1'b0, 1'b0, 7'd0,  KA ^ 48'h55,      1'b0, 1'b0, 7'd0,  4'd7},
        '{2'd0, 1'b0, 1'b1, 1'b1, 7'd2,  {W{1'b1}},        1'b0, 1'b0, 7'd0,  4'd6},  // R6
        '{2'd1, 1'b0, 1'b0, 1'b0, 7'd0,  48'hFFFF_FFFF_FF00, 1'b1, 1'b0, 7'd2, 4'd6},
        '{2'd1, 1'b0, 1'b0, 1'b0, 7'd0,  {W{1'b1}},        1'b0, 1'b0, 7'd0,  4'd6},
        '{2'd0, 1'b1, 1'b1, 1'b1, 7'd20, 48'h5555_5555_5555, 1'b0, 1'b0, 7'd0, 4'd8}, // R8
        '{2'd1, 1'b0, 1'b0, 1'b0, 7'd0,  48'hABCD_EF01_2300, 1'b1, 1'b0, 7'd20, 4'd8},
        '{2'd1, 1'b0, 1'b0, 1'b0, 7'd0,  48'h11,           1'b0, 1'b0, 7'd0,  4'd8},
        '{2'd0, 1'b0, 1'b0, 1'b0, 7'd30, KC,               1'b0, 1'b0, 7'd0,  4'd2},  // R2
        '{2'd1, 1'b0, 1'b0, 1'b0, 7'd0,  KC,               1'b0, 1'b0, 7'd0,  4'd2},
        '{2'd0, 1'b0, 1'b0, 1'b1, 7'd5,  KC,               1'b0, 1'b0, 7'd0,  4'd1},
        '{2'd1, 1'b0, 1'b0, 1'b0, 7'd0,  KA,               1'b1, 1'b0, 7'd9,  4'd5}   // R1 R5
    };

    task automatic chk(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_out(input string req, input logic eh, input logic em,
                           input logic [AW-1:0] ea);
        chk(req, "hit",       W'(hit),       W'(eh));
        chk(req, "multi_hit", W'(multi_hit), W'(em));
        chk(req, "hit_addr",  W'(hit_addr),  W'(ea));
    endtask

    task automatic idle();
        ce = 1'b0; wr_en = 1'b0; wr_cs = 1'b0; wr_dc = 1'b0;
        mask_en = 1'b0; mask_ld = 1'b0;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [W-1:0] d,
                            input logic dc, input logic men, input logic cs);
        @(negedge clk);
        ce = 1'b1; wr_en = 1'b1; wr_cs = cs; wr_dc = dc; mask_en = men;
        mask_ld = 1'b0; wr_addr = a; din = d;
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic do_mask(input logic [W-1:0] d);
        @(negedge clk);
        ce = 1'b1; wr_en = 1'b0; mask_ld = 1'b1; din = d;
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    // key held through two edges: sampled on the first, results registered on the second
    task automatic do_search(input logic [W-1:0] k, input logic men);
        @(negedge clk);
        ce = 1'b1; wr_en = 1'b0; wr_cs = 1'b0; mask_ld = 1'b0;
        mask_en = men; din = k;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1'b1; din = '0; wr_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        chk_out("R11", 1'b0, 1'b0, 7'd0);

        for (int i = 0; i < NV; i++) begin
            case (TBL[i].op)
                2'd0: do_write(TBL[i].addr, TBL[i].data, TBL[i].dc, TBL[i].men, TBL[i].cs);
                2'd2: do_mask(TBL[i].data);
                default: begin
                    do_search(TBL[i].data, TBL[i].men);
                    chk_out($sformatf("R%0d", TBL[i].req), TBL[i].ehit, TBL[i].emul, TBL[i].eaddr);
                end
            endcase
        end

        // R12: one edge after sampling the key, the old result still shows
        @(negedge clk);
        ce = 1'b1; mask_en = 1'b0; din = KC;
        @(posedge clk);
        @(negedge clk);
        chk_out("R12", 1'b1, 1'b0, 7'd9);
        @(posedge clk);
        @(negedge clk);
        idle();
        chk_out("R12", 1'b1, 1'b0, 7'd5);

        // R10: stalled write and search do nothing, outputs hold
        @(negedge clk);
        ce = 1'b0; wr_en = 1'b1; wr_cs = 1'b1; wr_addr = 7'd40; din = 48'hD00D;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_cs = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk_out("R10", 1'b1, 1'b0, 7'd5);
        do_search(48'hD00D, 1'b0);
        chk_out("R10", 1'b0, 1'b0, 7'd0);

        // R11: reset clears entries, mask and outputs
        do_search(KC, 1'b0);
        chk_out("R11", 1'b1, 1'b0, 7'd5);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk_out("R11", 1'b0, 1'b0, 7'd0);
        do_search(KC, 1'b0);
        chk_out("R11", 1'b0, 1'b0, 7'd0);
        do_write(7'd3, KA, 1'b0, 1'b0, 1'b1);
        do_search(KA ^ 48'h55, 1'b1);
        chk_out("R11", 1'b0, 1'b0, 7'd0);
        do_search(KA, 1'b1);
        chk_out("R11", 1'b1, 1'b0, 7'd3);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule